// File: doc/BRIEF.md
# Temperature Monitor Register Target

This block is the register side of a temperature monitor that sits on a two-wire serial bus. A bit-level bus engine, built elsewhere, turns bus activity into byte events: start, stop, byte written by the controller, and byte requested by the controller. The first byte written after a start or stop loads an 8-bit pointer. Every later byte moves data to or from one of four logical registers: the live temperature, a one-byte configuration, a hysteresis threshold and an over-temperature threshold. The three 16-bit registers move as two bytes, high byte first.

A per-transaction byte phase picks the high or low half. It saturates, so any extra bytes keep reaching the low half. Some pointer values outside the local space belong to a companion monitor. Accesses through those pointers are forwarded as a short transaction on a valid/ready request port aimed at the companion's bus address. While a forwarded access is in flight the block reports busy and holds back its read response until the companion's byte comes back.

Top module: `tsense_target`

## Requirements
- R1: After reset, configuration is 0x00, the hysteresis threshold is 0x4B00, the over-temperature threshold is 0x5000, and busy, rd_valid and rly_valid are all low.
- R2: For a locally decoded pointer, only pointer bits [1:0] choose the register: 0 selects temperature (from temp_in), 1 selects configuration, 2 the hysteresis threshold, 3 the over-temperature threshold. Configuration is always a single byte.
- R3: Temperature and both thresholds transfer the high byte (bits [15:8]) on the first data byte of a transaction and the low byte (bits [7:0]) on the second.
- R4: The byte phase clears at start and at stop and saturates after the first data byte, so the third and later data bytes of a transaction all reach the low byte.
- R5: Data writes to the temperature register change no state; data writes to configuration or to a threshold byte update that byte, visible on cfg_q, thyst_q and tos_q on the following cycle.
- R6: The first byte written after a start or stop always loads the pointer and never writes data; the pointer is kept across transactions, so a read that follows a start with no pointer write uses the last pointer and returns the high byte first.
- R7: A locally decoded read request produces a one-cycle rd_valid pulse on the next clock, with the byte on rd_data; events that arrive while busy is high are dropped.
- R8: An access is forwarded only when the pointer is greater than 7, pointer bits [7:3] differ from 5'b01010, and comp_addr bit 7 is 0; otherwise it is decoded locally and the request port stays idle.
- R9: A forwarded write issues, in order, the operations start (code 0), write of the pointer (code 1), write of the data byte (code 1) and stop (code 3), with rly_dev equal to comp_addr[6:0], and leaves local registers unchanged.
- R10: A forwarded read issues start (0), write of the pointer (1), read (code 2) and stop (3); the byte received on rly_rvalid/rly_rdata is returned on rd_data with a one-cycle rd_valid on the clock that accepts the stop.
- R11: Once rly_valid is high, rly_valid, rly_op and rly_wdata stay unchanged until rly_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start event pulse from the bus engine |
| ev_stop | input | 1 | Stop event pulse |
| ev_write | input | 1 | Byte-written event pulse |
| ev_wdata | input | 8 | Byte carried by ev_write |
| ev_read | input | 1 | Byte-requested event pulse |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the requested byte |
| rd_data | output | 8 | Response byte |
| busy | output | 1 | A forwarded access is in flight; events are dropped |
| temp_in | input | 16 | Current temperature from the conversion logic |
| comp_addr | input | 8 | Companion bus address; bit 7 set disables forwarding |
| cfg_q | output | 8 | Stored configuration |
| thyst_q | output | 16 | Stored hysteresis threshold |
| tos_q | output | 16 | Stored over-temperature threshold |
| rly_valid | output | 1 | Forwarding request valid |
| rly_ready | input | 1 | Forwarding request accepted |
| rly_op | output | 2 | Operation: 0 start, 1 write, 2 read, 3 stop |
| rly_dev | output | 7 | Companion bus address for the request |
| rly_wdata | output | 8 | Byte for a write operation, zero otherwise |
| rly_rvalid | input | 1 | Companion read byte valid |
| rly_rdata | input | 8 | Companion read byte |

## Verification
A wrong byte phase shows on the very next data byte as the wrong half of a 16-bit register, and for a write as the wrong half of thyst_q or tos_q one cycle later; the bench therefore reads and writes past the second byte and reads without a pointer write. A wrong pointer or forwarding decision shows immediately, either as a read response from the wrong register or as request traffic where none is due, so boundary pointers on both sides of the forwarding rule are exercised. A stuck or misordered forwarding sequencer shows within a few cycles as a missing or reordered operation log from the companion model or a read response that never arrives, including while the companion stalls rly_ready.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // Pointer bits [7:3] of the local window that is never forwarded
    localparam logic [4:0] LOCAL_WINDOW = 5'h0A;

    typedef enum logic [1:0] {
        SEL_TEMP  = 2'd0,
        SEL_CFG   = 2'd1,
        SEL_THYST = 2'd2,
        SEL_TOS   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RLY_START = 2'd0,
        RLY_WRITE = 2'd1,
        RLY_READ  = 2'd2,
        RLY_STOP  = 2'd3
    } rly_op_e;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_START,
        RS_PTR,
        RS_DATA,
        RS_WAIT,
        RS_STOP
    } rly_state_e;

    typedef struct packed {
        logic              is_read;
        logic [BYTE_W-1:0] ptr;
        logic [BYTE_W-1:0] wdata;
    } relay_req_t;

    function automatic logic needs_relay(input logic [BYTE_W-1:0] ptr,
                                         input logic [BYTE_W-1:0] comp);
        return (ptr > 8'd7) && (ptr[7:3] != LOCAL_WINDOW) && !comp[7];
    endfunction

    // Flat byte index: temp 0/1, cfg 2, hysteresis 3/4, over-temp 5/6
    function automatic logic [2:0] byte_index(input reg_sel_e sel, input logic lo);
        case (sel)
            SEL_TEMP:  return lo ? 3'd1 : 3'd0;
            SEL_CFG:   return 3'd2;
            SEL_THYST: return lo ? 3'd4 : 3'd3;
            default:   return lo ? 3'd6 : 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/tsense_ptr_seq.sv
module tsense_ptr_seq
    import tsense_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              wr_ev,
    input  logic              rd_ev,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ptr,
    output logic              lo_byte,
    output logic              data_wr,
    output logic              data_rd
);

    // 0: pointer expected, 1: high byte next, 2: low byte (saturated)
    logic [1:0] phase;

    assign data_wr = wr_ev && (phase != 2'd0);
    assign data_rd = rd_ev;
    assign lo_byte = (phase == 2'd2);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 2'd0;
            ptr   <= '0;
        end else if (start_ev || stop_ev) begin
            phase <= 2'd0;
        end else if (wr_ev && (phase == 2'd0)) begin
            ptr   <= wdata;
            phase <= 2'd1;
        end else if (data_wr || data_rd) begin
            phase <= 2'd2;
        end
    end

    p_phase_legal_r4: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3);

    p_saturate_r4: assert property (@(posedge clk) disable iff (rst)
        (data_wr || data_rd) && !start_ev && !stop_ev |=> lo_byte);

    p_ptr_load_r6: assert property (@(posedge clk) disable iff (rst)
        wr_ev && !lo_byte && !data_wr && !start_ev && !stop_ev |=> ptr == $past(wdata));

endmodule

// File: rtl/tsense_regs.sv
module tsense_regs
    import tsense_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CFG_RST   = 8'h00,
    parameter logic [WORD_W-1:0] THYST_RST = 16'h4B00,
    parameter logic [WORD_W-1:0] TOS_RST   = 16'h5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic              lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [WORD_W-1:0] temp_in,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] cfg_q,
    output logic [WORD_W-1:0] thyst_q,
    output logic [WORD_W-1:0] tos_q
);

    localparam int N_THR = 2;
    localparam logic [WORD_W-1:0] THR_RST [N_THR] = '{THYST_RST, TOS_RST};

    logic [2:0]                   idx;
    logic [N_THR-1:0][WORD_W-1:0] thr_w;
    logic [BYTE_W-1:0]            rd_mux;

    assign idx = byte_index(sel, lo);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RST;
        else if (wr_en && (idx == 3'd2))
            cfg_q <= wdata;
    end

    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        localparam logic [2:0] IDX_HI = 3'(3 + 2 * t);
        localparam logic [2:0] IDX_LO = 3'(4 + 2 * t);
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= THR_RST[t];
            else if (wr_en && (idx == IDX_HI))
                q[WORD_W-1:BYTE_W] <= wdata;
            else if (wr_en && (idx == IDX_LO))
                q[BYTE_W-1:0] <= wdata;
        end
        assign thr_w[t] = q;
    end

    assign thyst_q = thr_w[0];
    assign tos_q   = thr_w[1];

    always_comb begin
        case (idx)
            3'd0:    rd_mux = temp_in[WORD_W-1:BYTE_W];
            3'd1:    rd_mux = temp_in[BYTE_W-1:0];
            3'd2:    rd_mux = cfg_q;
            3'd3:    rd_mux = thr_w[0][WORD_W-1:BYTE_W];
            3'd4:    rd_mux = thr_w[0][BYTE_W-1:0];
            3'd5:    rd_mux = thr_w[1][WORD_W-1:BYTE_W];
            default: rd_mux = thr_w[1][BYTE_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= rd_mux;
        end
    end

    p_temp_ro_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en && (sel == SEL_TEMP) |=> $stable(cfg_q) && $stable(thyst_q) && $stable(tos_q));

    p_rd_next_r7: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

endmodule

// File: rtl/tsense_relay.sv
module tsense_relay
    import tsense_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  relay_req_t        req,
    input  logic              rly_ready,
    input  logic              rly_rvalid,
    input  logic [BYTE_W-1:0] rly_rdata,
    output logic              rly_valid,
    output rly_op_e           rly_op,
    output logic [BYTE_W-1:0] rly_wdata,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] done_data
);

    rly_state_e        state;
    relay_req_t        req_q;
    logic [BYTE_W-1:0] rd_q;

    assign busy      = (state != RS_IDLE);
    assign done_data = rd_q;

    always_comb begin
        rly_valid = 1'b0;
        rly_op    = RLY_STOP;
        rly_wdata = '0;
        case (state)
            RS_START: begin
                rly_valid = 1'b1;
                rly_op    = RLY_START;
            end
            RS_PTR: begin
                rly_valid = 1'b1;
                rly_op    = RLY_WRITE;
                rly_wdata = req_q.ptr;
            end
            RS_DATA: begin
                rly_valid = 1'b1;
                rly_op    = req_q.is_read ? RLY_READ : RLY_WRITE;
                rly_wdata = req_q.is_read ? '0 : req_q.wdata;
            end
            RS_STOP: begin
                rly_valid = 1'b1;
                rly_op    = RLY_STOP;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_IDLE;
            req_q <= '0;
            rd_q  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                RS_IDLE:  if (go) begin
                              req_q <= req;
                              state <= RS_START;
                          end
                RS_START: if (rly_ready) state <= RS_PTR;
                RS_PTR:   if (rly_ready) state <= RS_DATA;
                RS_DATA:  if (rly_ready) state <= req_q.is_read ? RS_WAIT : RS_STOP;
                RS_WAIT:  if (rly_rvalid) begin
                              rd_q  <= rly_rdata;
                              state <= RS_STOP;
                          end
                RS_STOP:  if (rly_ready) begin
                              state <= RS_IDLE;
                              done  <= req_q.is_read;
                          end
                default:  state <= RS_IDLE;
            endcase
        end
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        rly_valid && !rly_ready |=> rly_valid && $stable(rly_op) && $stable(rly_wdata));

    p_launch_r9: assert property (@(posedge clk) disable iff (rst)
        go && !busy |=> rly_valid && (rly_op == RLY_START));

    p_done_after_stop_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rly_valid && rly_ready && (rly_op == RLY_STOP)));

endmodule

// File: rtl/tsense_target.sv
module tsense_target
    import tsense_pkg::*;
#(
    parameter logic [7:0]  CFG_RST   = 8'h00,
    parameter logic [15:0] THYST_RST = 16'h4B00,
    parameter logic [15:0] TOS_RST   = 16'h5000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_start,
    input  logic        ev_stop,
    input  logic        ev_write,
    input  logic [7:0]  ev_wdata,
    input  logic        ev_read,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        busy,
    input  logic [15:0] temp_in,
    input  logic [7:0]  comp_addr,
    output logic [7:0]  cfg_q,
    output logic [15:0] thyst_q,
    output logic [15:0] tos_q,
    output logic        rly_valid,
    input  logic        rly_ready,
    output logic [1:0]  rly_op,
    output logic [6:0]  rly_dev,
    output logic [7:0]  rly_wdata,
    input  logic        rly_rvalid,
    input  logic [7:0]  rly_rdata
);

    logic              start_g, stop_g, wr_g, rd_g;
    logic [BYTE_W-1:0] ptr;
    logic              lo_byte, data_wr, data_rd, fwd;
    logic              loc_wr, loc_rd, rly_go;
    logic              loc_valid, rly_done;
    logic [BYTE_W-1:0] loc_data, rly_data;
    rly_op_e           op_e;
    relay_req_t        req;

    // Events are dropped while a forwarded access is in flight
    assign start_g = ev_start && !busy;
    assign stop_g  = ev_stop  && !busy;
    assign wr_g    = ev_write && !busy;
    assign rd_g    = ev_read  && !busy;

    tsense_ptr_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_ev (start_g),
        .stop_ev  (stop_g),
        .wr_ev    (wr_g),
        .rd_ev    (rd_g),
        .wdata    (ev_wdata),
        .ptr      (ptr),
        .lo_byte  (lo_byte),
        .data_wr  (data_wr),
        .data_rd  (data_rd)
    );

    assign fwd    = needs_relay(ptr, comp_addr);
    assign loc_wr = data_wr && !fwd;
    assign loc_rd = data_rd && !fwd;
    assign rly_go = (data_wr || data_rd) && fwd;

    assign req.is_read = data_rd;
    assign req.ptr     = ptr;
    assign req.wdata   = ev_wdata;

    tsense_regs #(
        .CFG_RST   (CFG_RST),
        .THYST_RST (THYST_RST),
        .TOS_RST   (TOS_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (loc_wr),
        .rd_en    (loc_rd),
        .sel      (reg_sel_e'(ptr[1:0])),
        .lo       (lo_byte),
        .wdata    (ev_wdata),
        .temp_in  (temp_in),
        .rd_valid (loc_valid),
        .rd_data  (loc_data),
        .cfg_q    (cfg_q),
        .thyst_q  (thyst_q),
        .tos_q    (tos_q)
    );

    tsense_relay u_relay (
        .clk        (clk),
        .rst        (rst),
        .go         (rly_go),
        .req        (req),
        .rly_ready  (rly_ready),
        .rly_rvalid (rly_rvalid),
        .rly_rdata  (rly_rdata),
        .rly_valid  (rly_valid),
        .rly_op     (op_e),
        .rly_wdata  (rly_wdata),
        .busy       (busy),
        .done       (rly_done),
        .done_data  (rly_data)
    );

    assign rly_op   = op_e;
    assign rly_dev  = comp_addr[6:0];
    assign rd_valid = loc_valid || rly_done;
    assign rd_data  = rly_done ? rly_data : loc_data;

    p_single_resp_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({loc_valid, rly_done}));

    p_local_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (data_wr || data_rd) && !fwd && !busy |=> !rly_valid);

endmodule

// File: tb/sim_tsense_target.sv
`timescale 1ns/1ps
module sim_tsense_target;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_start = 0, ev_stop = 0, ev_write = 0, ev_read = 0;
    logic [7:0]  ev_wdata = 0;
    logic        rd_valid, busy;
    logic [7:0]  rd_data;
    logic [15:0] temp_in = 16'h1A80;
    logic [7:0]  comp_addr = 8'hFF;
    logic [7:0]  cfg_q;
    logic [15:0] thyst_q, tos_q;
    logic        rly_valid;
    logic        rly_ready = 1'b1;
    logic [1:0]  rly_op;
    logic [6:0]  rly_dev;
    logic [7:0]  rly_wdata;
    logic        rly_rvalid = 1'b0;
    logic [7:0]  rly_rdata = 8'h00;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    bit stall_mode = 0;

    logic [1:0] log_op [16];
    logic [7:0] log_byte [16];
    int         log_n = 0;

    always #2.5 clk = ~clk;

    tsense_target u0 (
        .clk(clk), .rst(rst),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_write(ev_write),
        .ev_wdata(ev_wdata), .ev_read(ev_read),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .temp_in(temp_in), .comp_addr(comp_addr),
        .cfg_q(cfg_q), .thyst_q(thyst_q), .tos_q(tos_q),
        .rly_valid(rly_valid), .rly_ready(rly_ready), .rly_op(rly_op),
        .rly_dev(rly_dev), .rly_wdata(rly_wdata),
        .rly_rvalid(rly_rvalid), .rly_rdata(rly_rdata)
    );

    // Companion model: logs accepted operations, answers a read two cycles later
    initial begin
        int   cnt;
        logic [7:0] last_wr;
        cnt = 0;
        last_wr = 0;
        forever begin
            @(negedge clk);
            if (cnt > 0) begin
                cnt = cnt - 1;
                rly_rvalid = (cnt == 0);
                rly_rdata  = last_wr ^ 8'h5A;
            end else begin
                rly_rvalid = 1'b0;
            end
            rly_ready = stall_mode ? ~rly_ready : 1'b1;
            if (rly_valid && rly_ready && log_n < 16) begin
                log_op[log_n]   = rly_op;
                log_byte[log_n] = rly_wdata;
                log_n = log_n + 1;
                if (rly_op == 2'd1) last_wr = rly_wdata;
                if (rly_op == 2'd2) cnt = 2;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_start();
        wait_idle();
        ev_start = 1; @(negedge clk); ev_start = 0;
    endtask

    task automatic pulse_stop();
        wait_idle();
        ev_stop = 1; @(negedge clk); ev_stop = 0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        wait_idle();
        ev_write = 1; ev_wdata = b; @(negedge clk); ev_write = 0;
    endtask

    task automatic read_byte(output logic [7:0] d, output int lat);
        wait_idle();
        ev_read = 1; @(negedge clk); ev_read = 0;
        lat = 1;
        while (!rd_valid && lat < 60) begin
            @(negedge clk);
            lat = lat + 1;
        end
        d = rd_data;
    endtask

    logic [15:0] exp_thyst = 16'h4B00;
    logic [15:0] exp_tos   = 16'h5000;
    logic [7:0]  exp_cfg   = 8'h00;

    task automatic t_reset();
        check("R1 cfg reset", cfg_q, 8'h00);
        check("R1 thyst reset", thyst_q, 16'h4B00);
        check("R1 tos reset", tos_q, 16'h5000);
        check("R1 idle outputs", {busy, rd_valid, rly_valid}, 3'b000);
    endtask

    task automatic t_temp_read();
        logic [7:0] d; int lat;
        pulse_start(); write_byte(8'h00);
        read_byte(d, lat);
        check("R3 temp high byte", d, 8'h1A);
        check("R7 local read latency", lat, 1);
        @(negedge clk);
        check("R7 rd_valid single cycle", rd_valid, 1'b0);
        read_byte(d, lat);
        check("R3 temp low byte", d, 8'h80);
        read_byte(d, lat);
        check("R4 third byte stays low", d, 8'h80);
        pulse_stop();
    endtask

    task automatic t_thresh_write();
        logic [7:0] d; int lat;
        pulse_start(); write_byte(8'h02); write_byte(8'h55); write_byte(8'h66);
        pulse_stop();
        exp_thyst = 16'h5566;
        check("R5 thyst written", thyst_q, exp_thyst);
        pulse_start(); write_byte(8'h03);
        write_byte(8'h11); write_byte(8'h22); write_byte(8'h33);
        pulse_stop();
        exp_tos = 16'h1133;
        check("R4 extra write hits low byte", tos_q, exp_tos);
        pulse_start(); write_byte(8'h02); read_byte(d, lat);
        check("R2 thyst high readback", d, 8'h55);
        read_byte(d, lat);
        check("R2 thyst low readback", d, 8'h66);
        pulse_stop();
    endtask

    task automatic t_cfg();
        logic [7:0] d; int lat;
        pulse_start(); write_byte(8'h01); write_byte(8'hA5); write_byte(8'h3C);
        pulse_stop();
        exp_cfg = 8'h3C;
        check("R2 cfg single byte written", cfg_q, exp_cfg);
        check("R2 cfg write leaves thyst", thyst_q, exp_thyst);
        pulse_start(); write_byte(8'h01); read_byte(d, lat);
        check("R2 cfg read first", d, exp_cfg);
        read_byte(d, lat);
        check("R2 cfg read second", d, exp_cfg);
        pulse_stop();
    endtask

    task automatic t_temp_ro();
        logic [7:0] d; int lat;
        pulse_start(); write_byte(8'h00); write_byte(8'h77); write_byte(8'h88);
        pulse_stop();
        check("R5 temp write no state change", {cfg_q, thyst_q, tos_q},
              {exp_cfg, exp_thyst, exp_tos});
        pulse_start(); write_byte(8'h00); read_byte(d, lat);
        check("R5 temp still from input", d, 8'h1A);
        pulse_stop();
    endtask

    task automatic t_ptr_first();
        logic [7:0] d; int lat;
        pulse_start(); write_byte(8'h03);
        check("R6 pointer byte not data", tos_q, exp_tos);
        pulse_stop();
        pulse_start(); read_byte(d, lat);
        check("R6 retained pointer high first", d, exp_tos[15:8]);
        read_byte(d, lat);
        check("R6 retained pointer then low", d, exp_tos[7:0]);
        pulse_stop();
    endtask

    task automatic t_local_decode();
        logic [7:0] d; int lat;
        comp_addr = 8'hFF;
        log_n = 0;
        pulse_start(); write_byte(8'h0E); read_byte(d, lat);
        check("R8 no companion: local decode", d, exp_thyst[15:8]);
        pulse_stop();
        comp_addr = 8'h2D;
        pulse_start(); write_byte(8'h52); read_byte(d, lat);
        check("R8 window 0x50 stays local", d, exp_thyst[15:8]);
        check("R8 window read latency", lat, 1);
        pulse_stop();
        pulse_start(); write_byte(8'h07); read_byte(d, lat);
        check("R8 pointer 7 stays local", d, exp_tos[15:8]);
        pulse_stop();
        repeat (3) @(negedge clk);
        check("R8 no request traffic", log_n, 0);
    endtask

    task automatic t_relay_write();
        comp_addr = 8'h2D;
        log_n = 0;
        pulse_start(); write_byte(8'h20);
        check("R9 pointer write not forwarded", log_n, 0);
        write_byte(8'h9C);
        check("R9 busy during forward", busy, 1'b1);
        check("R9 target address", rly_dev, 7'h2D);
        wait_idle(); @(negedge clk);
        check("R9 op count", log_n, 4);
        check("R9 op sequence", {log_op[0], log_op[1], log_op[2], log_op[3]},
              {2'd0, 2'd1, 2'd1, 2'd3});
        check("R9 pointer then data", {log_byte[1], log_byte[2]}, {8'h20, 8'h9C});
        check("R9 local regs untouched", {cfg_q, thyst_q, tos_q},
              {exp_cfg, exp_thyst, exp_tos});
        pulse_stop();
    endtask

    task automatic t_relay_read(input bit stall, input logic [7:0] p);
        logic [7:0] d; int lat;
        comp_addr = 8'h2D;
        stall_mode = stall;
        pulse_start(); write_byte(p);
        log_n = 0;
        read_byte(d, lat);
        check(stall ? "R11 stalled read data" : "R10 forwarded read data", d, p ^ 8'h5A);
        check("R10 response after stop", {log_n[7:0], log_op[3]}, {8'd4, 2'd3});
        check("R10 op sequence", {log_op[0], log_op[1], log_op[2]},
              {2'd0, 2'd1, 2'd2});
        check("R10 pointer sent", log_byte[1], p);
        check("R10 slower than local", lat > 4, 1'b1);
        stall_mode = 0;
        pulse_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_temp_read();
        t_thresh_write();
        t_cfg();
        t_temp_ro();
        t_ptr_first();
        t_local_decode();
        t_relay_write();
        t_relay_read(1'b0, 8'h41);
        t_relay_read(1'b1, 8'hC3);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule